// File: doc/BRIEF.md
# Boot Strap Capture and Shared Pin Role Controller

This block owns a group of dual-purpose device pins whose job depends on the phase the chip is in. The two amplifier configuration straps are captured once, on the first clock edge after reset is released. The block keeps those two pins as inputs until firmware signals that initialization is finished. From then on they drive outputs: an active-low fault flag and the power-supply sync clock. The captured 2-bit value is the configuration mode for the rest of the chip, and modes 2 and 3 also enable the crossover filters.

A second pair of straps sets the output-stage configuration. This pair is never latched. It is synchronized and compared against the captured value on every cycle. Any disagreement raises a mismatch flag and, once the chip is running, pulls the fault pin low. During initialization, four more pins act as an SPI port: serial clock out, select in, and two data pins whose directions follow the select level. In the running phase the same four pins become monitor pins: two volume-encoder phase inputs, a temperature reference input and a bidirectional temperature pin.

A small sequencer has three phases. PH_CAPTURE is the reset state. It always moves to PH_INIT on the next edge, and that edge latches the straps. PH_INIT moves to PH_RUN on an edge where `init_done_i` is high. PH_RUN holds until reset. A routing stage picks one of three pin roles, ROLE_SPI_MASTER, ROLE_SPI_SLAVE or ROLE_MONITOR, from the phase and the select pin.

Top module: `pin_role_ctrl`

## Requirements
- R1: On the first clock edge after `rst_n` rises, the block captures the synchronized strap pins as {cfg1_pad_i, cfg0_pad_i} and presents the value on `mode_o`, where bit 1 comes from cfg1.
- R2: From reset until the run phase, `cfg0_pad_oe_o` and `cfg1_pad_oe_o` stay low.
- R3: In PH_INIT, the first edge that sees `init_done_i` high enters PH_RUN. `run_o` is high in PH_RUN and stays high until reset. In PH_RUN both cfg pad enables are high, `cfg1_pad_o` follows `psync_i`, and `cfg0_pad_o` equals NOT(`fault_i` OR mismatch).
- R4: After capture, `mode_o` does not change until the next reset, whatever happens on the strap pins.
- R5: `strap_mismatch_o` is high when the synchronized live pair {ostage1_i, ostage0_i} differs from the captured mode. It is low while in reset. The live pair is never latched.
- R6: `xover_en_o` is high for modes 2 and 3 and low for modes 0 and 1.
- R7: In the run phase, a mismatch drives the fault pin low even when `fault_i` is low.
- R8: Before the run phase, the clock pin is an output (`sck_pad_oe_o`=1) carrying `spi_sck_i`, and `spi_ss_n_o` follows `nss_pad_i`.
- R9: Before the run phase, `nss_pad_i` high selects master. In master mode the MOSI pin outputs `spi_out_i` and the MISO pin feeds `spi_in_o`. `nss_pad_i` low selects slave. In slave mode the MISO pin outputs `spi_out_i` and the MOSI pin feeds `spi_in_o`.
- R10: In the run phase, the clock and MISO pins are inputs. `enc_a_o` and `enc_b_o` follow the select and MISO pins two cycles late. `temp_ref_o` follows the clock pin. The MOSI pin is driven by `temp_io_out_i` under `temp_io_oe_i`, and its level appears on `temp_io_in_o`. `spi_in_o` is 0 and `spi_ss_n_o` is 1. Before the run phase, the encoder and temperature outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_done_i | input | 1 | Firmware initialization complete |
| cfg0_pad_i | input | 1 | Strap/fault pin input level |
| cfg1_pad_i | input | 1 | Strap/sync pin input level |
| ostage0_i | input | 1 | Live output-stage strap bit 0 |
| ostage1_i | input | 1 | Live output-stage strap bit 1 |
| fault_i | input | 1 | Active-high protection fault from core |
| psync_i | input | 1 | Supply sync clock from generator |
| spi_sck_i | input | 1 | SPI clock from engine |
| spi_out_i | input | 1 | Serial data from engine |
| temp_io_out_i | input | 1 | Temperature pin drive value |
| temp_io_oe_i | input | 1 | Temperature pin drive enable |
| sck_pad_i | input | 1 | Clock/temp-ref pin input level |
| miso_pad_i | input | 1 | MISO/encoder-B pin input level |
| mosi_pad_i | input | 1 | MOSI/temp pin input level |
| nss_pad_i | input | 1 | Select/encoder-A pin level |
| cfg0_pad_o | output | 1 | Strap/fault pin drive value |
| cfg0_pad_oe_o | output | 1 | Strap/fault pin enable |
| cfg1_pad_o | output | 1 | Strap/sync pin drive value |
| cfg1_pad_oe_o | output | 1 | Strap/sync pin enable |
| sck_pad_o | output | 1 | Clock pin drive value |
| sck_pad_oe_o | output | 1 | Clock pin enable |
| miso_pad_o | output | 1 | MISO pin drive value |
| miso_pad_oe_o | output | 1 | MISO pin enable |
| mosi_pad_o | output | 1 | MOSI pin drive value |
| mosi_pad_oe_o | output | 1 | MOSI pin enable |
| spi_in_o | output | 1 | Serial data to engine |
| spi_ss_n_o | output | 1 | Select level to engine |
| enc_a_o | output | 1 | Synchronized encoder phase A |
| enc_b_o | output | 1 | Synchronized encoder phase B |
| temp_ref_o | output | 1 | Temperature reference level |
| temp_io_in_o | output | 1 | Temperature pin level |
| mode_o | output | 2 | Captured configuration mode |
| xover_en_o | output | 1 | Crossover filter enable |
| strap_mismatch_o | output | 1 | Live strap disagrees with capture |
| run_o | output | 1 | Operating phase active |

## Verification
The assertions take for granted that reset is held for at least two clock cycles while the strap pins are stable, so the unreset synchronizer holds the real strap level when the capture edge arrives. They also take for granted that `init_done_i` comes from the core clock domain. The stimulus sets the straps before each reset, holds `rst_n` low for three cycles, and changes every input only on falling edges. After changing an input that passes through a synchronizer, it waits two rising edges before checking. Directed trials cover all four modes, both with and without a mismatch. Random trials toggle the strap pins after capture, flip the select level, and change the live straps in both phases.

// File: rtl/pinrole_pkg.sv
package pinrole_pkg;

    localparam int CFG_W = 2;

    typedef enum logic [1:0] {
        PH_CAPTURE = 2'd0,
        PH_INIT    = 2'd1,
        PH_RUN     = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        ROLE_SPI_MASTER = 2'd0,
        ROLE_SPI_SLAVE  = 2'd1,
        ROLE_MONITOR    = 2'd2
    } role_e;

    function automatic logic xover_for(input logic [CFG_W-1:0] mode);
        return (mode == 2'd2) || (mode == 2'd3);
    endfunction

endpackage

// File: rtl/pinrole_sync.sv
module pinrole_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        stg[0] <= d_i;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                stg[i] <= stg[i-1];
            end
        end
    endgenerate

    assign q_o = stg[STAGES-1];

endmodule

// File: rtl/pinrole_seq.sv
module pinrole_seq
    import pinrole_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_done_i,
    input  logic [CFG_W-1:0] strap_i,
    input  logic [CFG_W-1:0] ostage_i,
    output logic [CFG_W-1:0] mode_o,
    output logic             run_o,
    output logic             mismatch_o
);

    phase_e            state_q, state_d;
    logic [CFG_W-1:0]  cfg_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_CAPTURE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_CAPTURE: state_d = PH_INIT;
            PH_INIT:    state_d = init_done_i ? PH_RUN : PH_INIT;
            PH_RUN:     state_d = PH_RUN;
            default:    state_d = PH_CAPTURE;
        endcase
    end

    // Strap capture register, written only in the capture phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    cfg_q <= '0;
        else if (state_q == PH_CAPTURE) cfg_q <= strap_i;
    end

    // Outputs
    always_comb begin
        mode_o     = cfg_q;
        run_o      = (state_q == PH_RUN);
        mismatch_o = (state_q != PH_CAPTURE) && (ostage_i != cfg_q);
    end

    // R1
    capture_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_CAPTURE) |=> (cfg_q == $past(strap_i)));

    // R4
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PH_CAPTURE) |=> $stable(cfg_q));

    // R3
    run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_RUN) |=> (state_q == PH_RUN));

    // R3
    init_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_INIT && !init_done_i) |=> (state_q == PH_INIT));

endmodule

// File: rtl/pinrole_route.sv
module pinrole_route
    import pinrole_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic mismatch_i,
    input  logic fault_i,
    input  logic psync_i,
    input  logic spi_sck_i,
    input  logic spi_out_i,
    input  logic temp_io_out_i,
    input  logic temp_io_oe_i,
    input  logic sck_pad_i,
    input  logic miso_pad_i,
    input  logic mosi_pad_i,
    input  logic nss_pad_i,
    input  logic enc_a_s_i,
    input  logic enc_b_s_i,
    output logic cfg0_pad_o,
    output logic cfg0_pad_oe_o,
    output logic cfg1_pad_o,
    output logic cfg1_pad_oe_o,
    output logic sck_pad_o,
    output logic sck_pad_oe_o,
    output logic miso_pad_o,
    output logic miso_pad_oe_o,
    output logic mosi_pad_o,
    output logic mosi_pad_oe_o,
    output logic spi_in_o,
    output logic spi_ss_n_o,
    output logic enc_a_o,
    output logic enc_b_o,
    output logic temp_ref_o,
    output logic temp_io_in_o
);

    role_e role;

    always_comb begin
        if (run_i)          role = ROLE_MONITOR;
        else if (nss_pad_i) role = ROLE_SPI_MASTER;
        else                role = ROLE_SPI_SLAVE;
    end

    always_comb begin
        cfg0_pad_o    = 1'b1;
        cfg0_pad_oe_o = 1'b0;
        cfg1_pad_o    = 1'b0;
        cfg1_pad_oe_o = 1'b0;
        sck_pad_o     = 1'b0;
        sck_pad_oe_o  = 1'b0;
        miso_pad_o    = 1'b0;
        miso_pad_oe_o = 1'b0;
        mosi_pad_o    = 1'b0;
        mosi_pad_oe_o = 1'b0;
        spi_in_o      = 1'b0;
        spi_ss_n_o    = 1'b1;
        enc_a_o       = 1'b0;
        enc_b_o       = 1'b0;
        temp_ref_o    = 1'b0;
        temp_io_in_o  = 1'b0;
        unique case (role)
            ROLE_SPI_MASTER: begin
                sck_pad_o     = spi_sck_i;
                sck_pad_oe_o  = 1'b1;
                spi_ss_n_o    = nss_pad_i;
                mosi_pad_o    = spi_out_i;
                mosi_pad_oe_o = 1'b1;
                spi_in_o      = miso_pad_i;
            end
            ROLE_SPI_SLAVE: begin
                sck_pad_o     = spi_sck_i;
                sck_pad_oe_o  = 1'b1;
                spi_ss_n_o    = nss_pad_i;
                miso_pad_o    = spi_out_i;
                miso_pad_oe_o = 1'b1;
                spi_in_o      = mosi_pad_i;
            end
            ROLE_MONITOR: begin
                cfg0_pad_o    = ~(fault_i | mismatch_i);
                cfg0_pad_oe_o = 1'b1;
                cfg1_pad_o    = psync_i;
                cfg1_pad_oe_o = 1'b1;
                enc_a_o       = enc_a_s_i;
                enc_b_o       = enc_b_s_i;
                temp_ref_o    = sck_pad_i;
                mosi_pad_o    = temp_io_out_i;
                mosi_pad_oe_o = temp_io_oe_i;
                temp_io_in_o  = mosi_pad_i;
            end
            default: ;
        endcase
    end

    // R7
    fault_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && mismatch_i) |-> (cfg0_pad_oe_o && !cfg0_pad_o));

    // R9
    master_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && nss_pad_i) |-> (mosi_pad_oe_o && !miso_pad_oe_o));

    // R2
    cfg_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |-> (!cfg0_pad_oe_o && !cfg1_pad_oe_o));

endmodule

// File: rtl/pin_role_ctrl.sv
module pin_role_ctrl
    import pinrole_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       init_done_i,
    input  logic       cfg0_pad_i,
    input  logic       cfg1_pad_i,
    input  logic       ostage0_i,
    input  logic       ostage1_i,
    input  logic       fault_i,
    input  logic       psync_i,
    input  logic       spi_sck_i,
    input  logic       spi_out_i,
    input  logic       temp_io_out_i,
    input  logic       temp_io_oe_i,
    input  logic       sck_pad_i,
    input  logic       miso_pad_i,
    input  logic       mosi_pad_i,
    input  logic       nss_pad_i,
    output logic       cfg0_pad_o,
    output logic       cfg0_pad_oe_o,
    output logic       cfg1_pad_o,
    output logic       cfg1_pad_oe_o,
    output logic       sck_pad_o,
    output logic       sck_pad_oe_o,
    output logic       miso_pad_o,
    output logic       miso_pad_oe_o,
    output logic       mosi_pad_o,
    output logic       mosi_pad_oe_o,
    output logic       spi_in_o,
    output logic       spi_ss_n_o,
    output logic       enc_a_o,
    output logic       enc_b_o,
    output logic       temp_ref_o,
    output logic       temp_io_in_o,
    output logic [1:0] mode_o,
    output logic       xover_en_o,
    output logic       strap_mismatch_o,
    output logic       run_o
);

    localparam int ENC_W = 2;

    logic [CFG_W-1:0] strap_s, ostage_s, mode_w;
    logic [ENC_W-1:0] enc_s;
    logic             run_w, mismatch_w;

    pinrole_sync #(.W(CFG_W), .STAGES(SYNC_STAGES)) u_strap_sync (
        .clk (clk),
        .d_i ({cfg1_pad_i, cfg0_pad_i}),
        .q_o (strap_s)
    );

    pinrole_sync #(.W(CFG_W), .STAGES(SYNC_STAGES)) u_ostage_sync (
        .clk (clk),
        .d_i ({ostage1_i, ostage0_i}),
        .q_o (ostage_s)
    );

    pinrole_sync #(.W(ENC_W), .STAGES(SYNC_STAGES)) u_enc_sync (
        .clk (clk),
        .d_i ({miso_pad_i, nss_pad_i}),
        .q_o (enc_s)
    );

    pinrole_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .init_done_i (init_done_i),
        .strap_i     (strap_s),
        .ostage_i    (ostage_s),
        .mode_o      (mode_w),
        .run_o       (run_w),
        .mismatch_o  (mismatch_w)
    );

    pinrole_route u_route (
        .clk           (clk),
        .rst_n         (rst_n),
        .run_i         (run_w),
        .mismatch_i    (mismatch_w),
        .fault_i       (fault_i),
        .psync_i       (psync_i),
        .spi_sck_i     (spi_sck_i),
        .spi_out_i     (spi_out_i),
        .temp_io_out_i (temp_io_out_i),
        .temp_io_oe_i  (temp_io_oe_i),
        .sck_pad_i     (sck_pad_i),
        .miso_pad_i    (miso_pad_i),
        .mosi_pad_i    (mosi_pad_i),
        .nss_pad_i     (nss_pad_i),
        .enc_a_s_i     (enc_s[0]),
        .enc_b_s_i     (enc_s[1]),
        .cfg0_pad_o    (cfg0_pad_o),
        .cfg0_pad_oe_o (cfg0_pad_oe_o),
        .cfg1_pad_o    (cfg1_pad_o),
        .cfg1_pad_oe_o (cfg1_pad_oe_o),
        .sck_pad_o     (sck_pad_o),
        .sck_pad_oe_o  (sck_pad_oe_o),
        .miso_pad_o    (miso_pad_o),
        .miso_pad_oe_o (miso_pad_oe_o),
        .mosi_pad_o    (mosi_pad_o),
        .mosi_pad_oe_o (mosi_pad_oe_o),
        .spi_in_o      (spi_in_o),
        .spi_ss_n_o    (spi_ss_n_o),
        .enc_a_o       (enc_a_o),
        .enc_b_o       (enc_b_o),
        .temp_ref_o    (temp_ref_o),
        .temp_io_in_o  (temp_io_in_o)
    );

    assign mode_o           = mode_w;
    assign xover_en_o       = xover_for(mode_w);
    assign strap_mismatch_o = mismatch_w;
    assign run_o            = run_w;

    // R6
    xover_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xover_en_o |-> mode_o[1]);

endmodule

// File: tb/pin_role_ctrl_tb_top.sv
`timescale 1ns/1ps
module pin_role_ctrl_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic init_done = 1'b0;
    logic cfg0_in = 1'b0, cfg1_in = 1'b0, ost0 = 1'b0, ost1 = 1'b0;
    logic fault = 1'b0, psync = 1'b0, spi_sck = 1'b0, spi_out = 1'b0;
    logic tio_out = 1'b0, tio_oe = 1'b0;
    logic sck_in = 1'b0, miso_in = 1'b0, mosi_in = 1'b0, nss_in = 1'b1;
    logic cfg0_o, cfg0_oe, cfg1_o, cfg1_oe, sck_o, sck_oe;
    logic miso_o, miso_oe, mosi_o, mosi_oe;
    logic spi_in, spi_ss_n, enc_a, enc_b, temp_ref, tio_in;
    logic [1:0] mode;
    logic xover, mism, run;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pin_role_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .init_done_i(init_done),
        .cfg0_pad_i(cfg0_in), .cfg1_pad_i(cfg1_in),
        .ostage0_i(ost0), .ostage1_i(ost1),
        .fault_i(fault), .psync_i(psync), .spi_sck_i(spi_sck), .spi_out_i(spi_out),
        .temp_io_out_i(tio_out), .temp_io_oe_i(tio_oe),
        .sck_pad_i(sck_in), .miso_pad_i(miso_in), .mosi_pad_i(mosi_in), .nss_pad_i(nss_in),
        .cfg0_pad_o(cfg0_o), .cfg0_pad_oe_o(cfg0_oe),
        .cfg1_pad_o(cfg1_o), .cfg1_pad_oe_o(cfg1_oe),
        .sck_pad_o(sck_o), .sck_pad_oe_o(sck_oe),
        .miso_pad_o(miso_o), .miso_pad_oe_o(miso_oe),
        .mosi_pad_o(mosi_o), .mosi_pad_oe_o(mosi_oe),
        .spi_in_o(spi_in), .spi_ss_n_o(spi_ss_n),
        .enc_a_o(enc_a), .enc_b_o(enc_b), .temp_ref_o(temp_ref), .temp_io_in_o(tio_in),
        .mode_o(mode), .xover_en_o(xover), .strap_mismatch_o(mism), .run_o(run)
    );

    function automatic logic exp_xover(input logic [1:0] m);
        return m[1];
    endfunction

    function automatic logic exp_fault_pad(input logic f, input logic mm);
        return ~(f | mm);
    endfunction

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic trial(input logic [1:0] strap, input logic [1:0] ost);
        logic [1:0] cur_ost;
        cur_ost = ost;
        @(negedge clk);
        rst_n = 1'b0; init_done = 1'b0;
        {cfg1_in, cfg0_in} = strap;
        {ost1, ost0} = ost;
        repeat (3) @(negedge clk);
        #1;
        chk("R3 run low in reset", {3'b0, run}, 4'h0);
        chk("R2 cfg oe in reset", {2'b0, cfg1_oe, cfg0_oe}, 4'h0);
        chk("R5 mismatch low in reset", {3'b0, mism}, 4'h0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R1 captured mode", {2'b0, mode}, {2'b0, strap});
        chk("R6 crossover enable", {3'b0, xover}, {3'b0, exp_xover(strap)});
        chk("R5 mismatch after capture", {3'b0, mism}, {3'b0, (ost != strap)});
        // Init phase: SPI roles, straps toggled
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            nss_in = 1'($urandom); spi_sck = 1'($urandom); spi_out = 1'($urandom);
            miso_in = 1'($urandom); mosi_in = 1'($urandom);
            cfg0_in = 1'($urandom); cfg1_in = 1'($urandom);
            #1;
            chk("R2 cfg oe in init", {2'b0, cfg1_oe, cfg0_oe}, 4'h0);
            chk("R8 sck pad", {2'b0, sck_oe, sck_o}, {2'b0, 1'b1, spi_sck});
            chk("R8 select pass", {3'b0, spi_ss_n}, {3'b0, nss_in});
            if (nss_in) begin
                chk("R9 master dir", {2'b0, mosi_oe, miso_oe}, 4'b0010);
                chk("R9 master data", {2'b0, mosi_o, spi_in}, {2'b0, spi_out, miso_in});
            end else begin
                chk("R9 slave dir", {2'b0, mosi_oe, miso_oe}, 4'b0001);
                chk("R9 slave data", {2'b0, miso_o, spi_in}, {2'b0, spi_out, mosi_in});
            end
            chk("R10 monitor outs idle in init", {enc_a, enc_b, temp_ref, tio_in}, 4'h0);
            chk("R4 mode held in init", {2'b0, mode}, {2'b0, strap});
        end
        // Live strap change in init
        @(negedge clk);
        cur_ost = 2'($urandom);
        {ost1, ost0} = cur_ost;
        repeat (2) @(negedge clk);
        #1;
        chk("R5 live mismatch init", {3'b0, mism}, {3'b0, (cur_ost != strap)});
        // Enter run
        init_done = 1'b1;
        @(negedge clk);
        init_done = 1'b0;
        #1;
        chk("R3 run entered", {3'b0, run}, 4'h1);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            fault = 1'($urandom); psync = 1'($urandom);
            tio_out = 1'($urandom); tio_oe = 1'($urandom);
            sck_in = 1'($urandom); mosi_in = 1'($urandom);
            nss_in = 1'($urandom); miso_in = 1'($urandom);
            cfg0_in = 1'($urandom); cfg1_in = 1'($urandom);
            if (i == 2) cur_ost = 2'($urandom);
            {ost1, ost0} = cur_ost;
            repeat (2) @(negedge clk);
            #1;
            chk("R3 run sticky", {3'b0, run}, 4'h1);
            chk("R3 cfg oe in run", {2'b0, cfg1_oe, cfg0_oe}, 4'h3);
            chk("R3 sync pad", {3'b0, cfg1_o}, {3'b0, psync});
            chk("R5 live mismatch run", {3'b0, mism}, {3'b0, (cur_ost != strap)});
            chk("R7 fault pad", {3'b0, cfg0_o}, {3'b0, exp_fault_pad(fault, cur_ost != strap)});
            chk("R10 encoder", {2'b0, enc_a, enc_b}, {2'b0, nss_in, miso_in});
            chk("R10 pin dirs", {2'b0, sck_oe, miso_oe}, 4'h0);
            chk("R10 temp pin", {mosi_oe, mosi_o, temp_ref, tio_in},
                {tio_oe, tio_out, sck_in, mosi_in});
            chk("R10 spi idle", {2'b0, spi_in, spi_ss_n}, 4'b0001);
            chk("R4 mode held in run", {2'b0, mode}, {2'b0, strap});
        end
    endtask

    initial begin
        void'($urandom(32'h5A17));
        // Directed: every mode, matched and mismatched live strap
        for (int m = 0; m < 4; m++) begin
            trial(2'(m), 2'(m));
            trial(2'(m), 2'(m) ^ 2'b01);
        end
        for (int t = 0; t < 16; t++) begin
            trial(2'($urandom), 2'($urandom));
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule